// File: doc/BRIEF.md
# Vector byte immediate logic unit

This block is the execute stage for bitwise immediate operations on a 128-bit SIMD register file. It treats the vector as sixteen independent byte lanes and copies an 8-bit immediate into every lane. It then applies one of seven operations to the whole vector in one step. Four of the operations combine the source vector with the immediate: AND, OR, XOR and NOR. Three of them also take the current destination value as an operand. Two of these merge source bits into the old destination, using the immediate as the per-bit mask. The third, the select form, uses the old destination as the mask that picks between the immediate and the source.

The decode stage presents the operation code, the immediate, both vector operands, the destination register index and a write-tracking enable with a one-cycle valid pulse. One cycle later the block returns the result vector with a write strobe. An operation code outside the defined set produces a reserved-instruction pulse instead, and no write takes place. When tracking is enabled, every result write also sets the bit of a 32-bit modified-register mask that belongs to the destination register. The mask is sticky and is cleared only by reset.

Top module: `vec_imm_logic`

## Requirements
- R1: Code 0 (AND), code 1 (OR) and code 3 (XOR) give, in every byte lane, the source byte combined bitwise with the immediate.
- R2: Code 2 (NOR) gives, in every byte lane, the inverse of the source byte OR the immediate.
- R3: Code 4 (move-if-set) takes each result bit from the source where the corresponding immediate bit is 1, and from the old destination where it is 0.
- R4: Code 5 (move-if-clear) takes each result bit from the old destination where the corresponding immediate bit is 1, and from the source where it is 0.
- R5: Code 6 (select) takes each result bit from the immediate where the old destination bit is 1, and from the source where it is 0.
- R6: A valid input with codes 0 to 6 raises `res_wr` for exactly the next cycle, and `res_vec` carries the result in that cycle. Without a valid input, `res_wr` stays low and `res_vec` keeps its value.
- R7: A valid input with code 7 raises `rsvd_exc` for the next cycle only. `res_wr` stays low, and `res_vec` and `mod_mask` are unchanged.
- R8: A valid write with `track_en` high sets bit `dst_idx` of `mod_mask` in the same cycle that `res_wr` is high. All other mask bits keep their values.
- R9: With `track_en` low, or with no write, `mod_mask` keeps its previous value.
- R10: A synchronous active-high reset clears `res_vec`, `res_wr`, `rsvd_exc` and `mod_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code (0 AND, 1 OR, 2 NOR, 3 XOR, 4 move-if-set, 5 move-if-clear, 6 select, 7 reserved) |
| imm | input | 8 | Immediate, copied to every byte lane |
| src_vec | input | 128 | Source vector |
| dst_old | input | 128 | Current value of the destination register |
| dst_idx | input | 5 | Destination register index |
| track_en | input | 1 | Write-tracking enable |
| res_vec | output | 128 | Registered result vector |
| res_wr | output | 1 | Result write strobe |
| rsvd_exc | output | 1 | Reserved-instruction pulse |
| mod_mask | output | 32 | Per-register modified mask |

## Verification
Every result, the write strobe, the exception pulse and the mask update are due exactly one clock edge after the input cycle that causes them. The bench drives inputs on the falling edge and predicts the outputs from a bit-level model. It then compares at the next falling edge, so each comparison sees the state after exactly one rising edge. Idle cycles check that `res_vec` and `mod_mask` hold their values when no write occurs.

// File: rtl/vec_imm_logic.sv
module vec_imm_logic #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  parameter int REGS   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2:0]                op_sel,
  input  logic [LANE_W-1:0]         imm,
  input  logic [LANES*LANE_W-1:0]   src_vec,
  input  logic [LANES*LANE_W-1:0]   dst_old,
  input  logic [$clog2(REGS)-1:0]   dst_idx,
  input  logic                      track_en,
  output logic [LANES*LANE_W-1:0]   res_vec,
  output logic                      res_wr,
  output logic                      rsvd_exc,
  output logic [REGS-1:0]           mod_mask
);
  localparam int VW = LANES * LANE_W;

  logic [VW-1:0] imm_rep;
  logic [VW-1:0] nxt;
  logic          legal;

  assign imm_rep = {LANES{imm}};

  always_comb begin
    legal = 1'b1;
    case (op_sel)
      3'd0: nxt = src_vec & imm_rep;
      3'd1: nxt = src_vec | imm_rep;
      3'd2: nxt = ~(src_vec | imm_rep);
      3'd3: nxt = src_vec ^ imm_rep;
      3'd4: nxt = (src_vec & imm_rep) | (dst_old & ~imm_rep);
      3'd5: nxt = (dst_old & imm_rep) | (src_vec & ~imm_rep);
      3'd6: nxt = (imm_rep & dst_old) | (src_vec & ~dst_old);
      default: begin
        nxt   = '0;
        legal = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vec  <= '0;
      res_wr   <= 1'b0;
      rsvd_exc <= 1'b0;
      mod_mask <= '0;
    end else begin
      res_wr   <= in_valid && legal;
      rsvd_exc <= in_valid && !legal;
      if (in_valid && legal) begin
        res_vec <= nxt;
        if (track_en) mod_mask[dst_idx] <= 1'b1;
      end
    end
  end

  AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 3'd7) |=> (res_wr && !rsvd_exc)); // R6
  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd7) |=> (rsvd_exc && !res_wr && $stable(mod_mask) && $stable(res_vec))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_wr && !rsvd_exc && $stable(res_vec))); // R6
  AST_MASK_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && track_en && op_sel != 3'd7) |=> mod_mask[$past(dst_idx)]); // R8
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(mod_mask) & ~mod_mask) == '0)); // R8
  AST_MASK_UNTRACKED: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && track_en) |=> $stable(mod_mask)); // R9
endmodule

// File: tb/vec_imm_logic_tb.sv
module vec_imm_logic_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [2:0]   op_sel;
  logic [7:0]   imm;
  logic [127:0] src_vec, dst_old;
  logic [4:0]   dst_idx;
  logic         track_en;
  logic [127:0] res_vec;
  logic         res_wr, rsvd_exc;
  logic [31:0]  mod_mask;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [127:0] exp_res;
  logic [31:0]  exp_mask;

  always #10 clk = ~clk;

  vec_imm_logic dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .imm(imm),
    .src_vec(src_vec), .dst_old(dst_old), .dst_idx(dst_idx), .track_en(track_en),
    .res_vec(res_vec), .res_wr(res_wr), .rsvd_exc(rsvd_exc), .mod_mask(mod_mask)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [2:0] op, input logic [7:0] im,
                                          input logic [127:0] s, input logic [127:0] d);
    logic [127:0] r = '0;
    for (int b = 0; b < 128; b++) begin
      logic ib = im[b % 8];
      case (op)
        3'd0: r[b] = s[b] & ib;
        3'd1: r[b] = s[b] | ib;
        3'd2: r[b] = !(s[b] | ib);
        3'd3: r[b] = s[b] ^ ib;
        3'd4: r[b] = ib ? s[b] : d[b];
        3'd5: r[b] = ib ? d[b] : s[b];
        3'd6: r[b] = d[b] ? ib : s[b];
        default: r[b] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd3: return "R1";
      3'd2: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [7:0] im, input logic [127:0] s,
                       input logic [127:0] d, input logic [4:0] idx, input logic trk);
    logic legal = (op != 3'd7);
    in_valid = 1'b1; op_sel = op; imm = im; src_vec = s; dst_old = d;
    dst_idx = idx; track_en = trk;
    if (legal) begin
      exp_res = model(op, im, s, d);
      if (trk) exp_mask[idx] = 1'b1;
    end
    @(negedge clk);
    chk(legal ? "R6 res_wr" : "R7 res_wr", {127'd0, res_wr}, {127'd0, legal});
    chk("R7 rsvd_exc", {127'd0, rsvd_exc}, {127'd0, !legal});
    chk(op_tag(op), res_vec, exp_res);
    chk(trk ? "R8 mod_mask" : "R9 mod_mask", {96'd0, mod_mask}, {96'd0, exp_mask});
    in_valid = 1'b0;
  endtask

  task automatic idle();
    in_valid = 1'b0; op_sel = 3'($urandom); imm = 8'($urandom);
    src_vec = {4{$urandom}}; dst_idx = 5'($urandom); track_en = 1'b1;
    @(negedge clk);
    chk("R6 idle res_wr", {127'd0, res_wr}, 128'd0);
    chk("R6 idle res_vec", res_vec, exp_res);
    chk("R9 idle mod_mask", {96'd0, mod_mask}, {96'd0, exp_mask});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    exp_res = '0; exp_mask = '0;
    chk("R10 res_vec", res_vec, 128'd0);
    chk("R10 res_wr", {127'd0, res_wr}, 128'd0);
    chk("R10 rsvd_exc", {127'd0, rsvd_exc}, 128'd0);
    chk("R10 mod_mask", {96'd0, mod_mask}, 128'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] pat, alt;
    pat = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    alt = {8{16'hF00F}};
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; imm = '0; src_vec = '0;
    dst_old = '0; dst_idx = '0; track_en = 1'b0;
    exp_res = '0; exp_mask = '0;
    @(negedge clk);
    do_reset();

    apply(3'd0, 8'h0F, pat, alt, 5'd0, 1'b0);   // R1 AND
    apply(3'd1, 8'h81, pat, alt, 5'd1, 1'b1);   // R1 OR, R8
    apply(3'd3, 8'hFF, pat, alt, 5'd31, 1'b1);  // R1 XOR, R8 top index
    apply(3'd2, 8'h00, pat, alt, 5'd2, 1'b0);   // R2 NOR
    apply(3'd2, 8'hFF, pat, alt, 5'd2, 1'b0);   // R2 NOR all ones
    apply(3'd4, 8'hA5, pat, alt, 5'd4, 1'b1);   // R3
    apply(3'd4, 8'h00, pat, alt, 5'd4, 1'b0);   // R3 keeps destination
    apply(3'd5, 8'hA5, pat, alt, 5'd5, 1'b1);   // R4
    apply(3'd5, 8'hFF, pat, alt, 5'd5, 1'b0);   // R4 keeps destination
    apply(3'd6, 8'h3C, pat, alt, 5'd6, 1'b1);   // R5
    apply(3'd6, 8'hC3, pat, '1, 5'd6, 1'b0);    // R5 immediate everywhere
    idle();                                     // R6
    apply(3'd7, 8'h55, pat, alt, 5'd9, 1'b1);   // R7 reserved, mask unchanged
    apply(3'd0, 8'hFF, ~pat, alt, 5'd10, 1'b0); // R9 untracked
    idle();

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 5) == 0) idle();
      else apply(3'($urandom), 8'($urandom), {4{$urandom}}, {4{$urandom}},
                 5'($urandom), 1'($urandom));
    end

    apply(3'd1, 8'h11, pat, alt, 5'd17, 1'b1);
    do_reset();                                 // R10 mid-run
    apply(3'd3, 8'h5A, pat, alt, 5'd3, 1'b1);   // R8 after reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule